// File: doc/BRIEF.md
# Single-Transfer DMA Request Handshake

This block links one endpoint buffer to an external DMA controller with a request/acknowledge handshake. Each of the endpoints numbered 1 to NUM_EP can be set to CPU access or DMA access, and to the IN or OUT direction. A select input picks which endpoint is bound to the DMA data port. When that endpoint is in DMA mode and its buffer is ready for its direction, the block raises a request. For OUT, ready means the buffer holds data to read. For IN, ready means it has space to write. The acknowledge clears the request. While the acknowledge is active it serves as both chip select and port address, and a read or write strobe then moves exactly one 8-bit or 16-bit word.

For OUT endpoints in DMA mode, the block counts down the bytes of a received short packet as the controller drains them. It raises a sticky buffer-ready interrupt once the last byte has been read. It also publishes a short-packet length. In the normal receive mode this is the byte count of the short packet. In continuous receive mode it is the number of bytes that arrived in full packets ahead of the short one. No buffer-ready interrupt is ever raised for IN.

Top module: `dma_single_xfer`

## Requirements
- R1: A request is raised only when the selected endpoint is in DMA mode. An endpoint in CPU mode, and the select value 0, never raise one.
- R2: The request rises one clock after the buffer is seen ready. Ready is `buf_has_data` for an OUT endpoint (`cfg_in`=0) and `buf_has_space` for an IN endpoint (`cfg_in`=1).
- R3: The request falls on the clock after the acknowledge is sampled high.
- R4: After the acknowledge, a word moves only on a strobe that matches the endpoint direction while the acknowledge is high. A read strobe gives a one-cycle `fifo_rd` pulse, with `dbus_out` and `dbus_oe` valid. A write strobe gives a one-cycle `fifo_wr` pulse, with `fifo_wdata` taken from `dbus_in`. A strobe without the acknowledge, or of the wrong direction, is ignored.
- R5: Each request moves one word, however long the strobe is held. With `wide`=1 all 16 bits move. With `wide`=0 only bits 7:0 move and bits 15:8 read as zero.
- R6: No new request is raised until the strobe that completed the word is released. Buffer readiness is then checked again.
- R7: For an OUT endpoint in DMA mode, a short packet (`rx_pkt_short`=1 with `rx_pkt_valid`) of L bytes sets `irq_rdy` only after the reads have drained all L bytes. Each read drains 2 bytes when `wide`=1 and 1 byte otherwise, and never more than remain. A zero-length short packet sets it at once.
- R8: An endpoint set to IN never sets `irq_rdy`, and its packet events are ignored.
- R9: With `cont_mode`=0, `short_len` takes the byte count of the short packet.
- R10: With `cont_mode`=1, `short_len` takes the sum of the full-packet lengths received since the previous short packet.
- R11: `irq_rdy` stays set until a cycle with `irq_clr`=1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for endpoint configuration |
| cfg_ep | input | EPW | Endpoint being configured (1..NUM_EP) |
| cfg_dma | input | 1 | 1 = DMA mode, 0 = CPU mode |
| cfg_in | input | 1 | 1 = IN (to host), 0 = OUT (from host) |
| dma_ep | input | EPW | Endpoint bound to the DMA port, 0 = none |
| wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| cont_mode | input | 1 | Continuous receive mode for the length register |
| buf_has_data | input | 1 | Selected buffer holds data to read |
| buf_has_space | input | 1 | Selected buffer has room to write |
| rx_pkt_valid | input | 1 | One-cycle packet-received event |
| rx_pkt_short | input | 1 | The received packet was short |
| rx_pkt_len | input | LENW | Byte count of the received packet |
| dack | input | 1 | DMA acknowledge (chip select and port address) |
| rd_strobe | input | 1 | Read strobe |
| wr_strobe | input | 1 | Write strobe |
| dbus_in | input | 16 | Data from controller side |
| fifo_rdata | input | 16 | Head word of the buffer |
| irq_clr | input | 1 | Clears the buffer-ready interrupt |
| dreq | output | 1 | DMA request |
| fifo_rd | output | 1 | Pop one word from the buffer |
| fifo_wr | output | 1 | Push one word into the buffer |
| fifo_wdata | output | 16 | Word pushed into the buffer |
| dbus_out | output | 16 | Word returned to the controller |
| dbus_oe | output | 1 | Drive enable for `dbus_out` |
| irq_rdy | output | 1 | Sticky buffer-ready interrupt |
| short_len | output | LENW | Short-packet length register |

## Verification
The hardest state to reach is the moment a short packet's last byte is drained. This needs a packet event, then exactly the right number of complete handshakes, each with its own width. In 16-bit mode an odd length ends on a single byte. The bench arrives there with randomly chosen lengths and widths. Before each read it predicts whether the interrupt must still be low, and after each read whether it must be set. It also adds directed cases for zero length, odd length and continuous accumulation.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_ACK, ST_STRB} hs_state_t;
  typedef struct packed {
    logic dma;
    logic dir_in;
  } ep_cfg_t;
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs import dma_pkg::*; #(
  parameter int NUM_EP = 5,
  localparam int EPW = $clog2(NUM_EP + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [EPW-1:0] cfg_ep,
  input  logic           cfg_dma,
  input  logic           cfg_in,
  input  logic [EPW-1:0] sel_ep,
  output ep_cfg_t        sel_cfg,
  output logic           sel_valid
);
  ep_cfg_t cfg_q [NUM_EP];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk) begin
      if (rst) cfg_q[i] <= '0;
      else if (cfg_we && (cfg_ep == EPW'(i + 1))) cfg_q[i] <= '{dma: cfg_dma, dir_in: cfg_in};
    end
  end

  always_comb begin
    sel_cfg   = '0;
    sel_valid = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel_ep == EPW'(i + 1)) begin
        sel_cfg   = cfg_q[i];
        sel_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_handshake_fsm.sv
module dma_handshake_fsm import dma_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready_ok,
  input  logic          dir_in,
  input  logic          wide,
  input  logic          dack,
  input  logic          rd_strobe,
  input  logic          wr_strobe,
  input  logic [DW-1:0] dbus_in,
  input  logic [DW-1:0] fifo_rdata,
  output logic          dreq,
  output logic          fifo_rd,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe
);
  localparam int BW = DW / 2;
  hs_state_t st;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic w);
    return w ? d : {{(DW-BW){1'b0}}, d[BW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      dreq       <= 1'b0;
      fifo_rd    <= 1'b0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      dbus_out   <= '0;
      dbus_oe    <= 1'b0;
    end else begin
      fifo_rd <= 1'b0;
      fifo_wr <= 1'b0;
      unique case (st)
        ST_IDLE: if (ready_ok) begin
          st   <= ST_REQ;
          dreq <= 1'b1;
        end
        ST_REQ: if (dack) begin
          st   <= ST_ACK;
          dreq <= 1'b0;
        end
        ST_ACK: begin
          if (dack && rd_strobe && !dir_in) begin
            fifo_rd  <= 1'b1;
            dbus_out <= fit(fifo_rdata, wide);
            dbus_oe  <= 1'b1;
            st       <= ST_STRB;
          end else if (dack && wr_strobe && dir_in) begin
            fifo_wr    <= 1'b1;
            fifo_wdata <= fit(dbus_in, wide);
            st         <= ST_STRB;
          end
        end
        ST_STRB: if (!rd_strobe && !wr_strobe) begin
          st      <= ST_IDLE;
          dbus_oe <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_ready_chk: assert property (@(posedge clk) disable iff (rst) $rose(dreq) |-> $past(ready_ok));
  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst) (dreq && dack) |=> !dreq);
  // R4
  rd_needs_ack_chk: assert property (@(posedge clk) disable iff (rst) fifo_rd |-> $past(dack && rd_strobe));
  // R4
  wr_needs_ack_chk: assert property (@(posedge clk) disable iff (rst) fifo_wr |-> $past(dack && wr_strobe));
  // R5
  one_word_chk: assert property (@(posedge clk) disable iff (rst) (fifo_rd || fifo_wr) |=> !(fifo_rd || fifo_wr));
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({fifo_rd, fifo_wr}));
  // R6
  no_rereq_chk: assert property (@(posedge clk) disable iff (rst) (fifo_rd || fifo_wr) |=> !dreq);
endmodule

// File: rtl/short_pkt_tracker.sv
module short_pkt_tracker #(
  parameter int LENW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dma_out,
  input  logic            cont_mode,
  input  logic            wide,
  input  logic            rx_pkt_valid,
  input  logic            rx_pkt_short,
  input  logic [LENW-1:0] rx_pkt_len,
  input  logic            word_read,
  input  logic            irq_clr,
  output logic            irq_rdy,
  output logic [LENW-1:0] short_len
);
  logic [LENW-1:0] remain, acc, step, left;
  logic            pend, drained;

  always_comb begin
    step    = (wide && remain >= LENW'(2)) ? LENW'(2) : LENW'(1);
    left    = remain - step;
    drained = pend && word_read && (left == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= '0;
      acc       <= '0;
      pend      <= 1'b0;
      irq_rdy   <= 1'b0;
      short_len <= '0;
    end else begin
      if (irq_clr) irq_rdy <= 1'b0;
      if (!dma_out) begin
        pend <= 1'b0;
      end else if (rx_pkt_valid) begin
        if (rx_pkt_short) begin
          short_len <= cont_mode ? acc : rx_pkt_len;
          acc       <= '0;
          remain    <= rx_pkt_len;
          pend      <= (rx_pkt_len != '0);
          if (rx_pkt_len == '0) irq_rdy <= 1'b1;
        end else begin
          acc <= acc + rx_pkt_len;
        end
      end else if (pend && word_read) begin
        remain <= left;
        if (drained) begin
          pend    <= 1'b0;
          irq_rdy <= 1'b1;
        end
      end
    end
  end

  // R8
  irq_out_only_chk: assert property (@(posedge clk) disable iff (rst) $rose(irq_rdy) |-> $past(dma_out));
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst) (irq_rdy && !irq_clr) |=> irq_rdy);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(irq_rdy) |-> $past(rx_pkt_valid || word_read));
endmodule

// File: rtl/dma_single_xfer.sv
module dma_single_xfer import dma_pkg::*; #(
  parameter int NUM_EP = 5,
  parameter int LENW   = 12,
  parameter int DW     = 16,
  localparam int EPW   = $clog2(NUM_EP + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [EPW-1:0]  cfg_ep,
  input  logic            cfg_dma,
  input  logic            cfg_in,
  input  logic [EPW-1:0]  dma_ep,
  input  logic            wide,
  input  logic            cont_mode,
  input  logic            buf_has_data,
  input  logic            buf_has_space,
  input  logic            rx_pkt_valid,
  input  logic            rx_pkt_short,
  input  logic [LENW-1:0] rx_pkt_len,
  input  logic            dack,
  input  logic            rd_strobe,
  input  logic            wr_strobe,
  input  logic [DW-1:0]   dbus_in,
  input  logic [DW-1:0]   fifo_rdata,
  input  logic            irq_clr,
  output logic            dreq,
  output logic            fifo_rd,
  output logic            fifo_wr,
  output logic [DW-1:0]   fifo_wdata,
  output logic [DW-1:0]   dbus_out,
  output logic            dbus_oe,
  output logic            irq_rdy,
  output logic [LENW-1:0] short_len
);
  ep_cfg_t sel_cfg;
  logic    sel_valid, ready_ok, dma_out;

  ep_cfg_regs #(.NUM_EP(NUM_EP)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_dma(cfg_dma),
    .cfg_in(cfg_in), .sel_ep(dma_ep), .sel_cfg(sel_cfg), .sel_valid(sel_valid)
  );

  assign ready_ok = sel_valid && sel_cfg.dma && (sel_cfg.dir_in ? buf_has_space : buf_has_data);
  assign dma_out  = sel_valid && sel_cfg.dma && !sel_cfg.dir_in;

  dma_handshake_fsm #(.DW(DW)) u_hs (
    .clk(clk), .rst(rst), .ready_ok(ready_ok), .dir_in(sel_cfg.dir_in), .wide(wide),
    .dack(dack), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .dbus_in(dbus_in),
    .fifo_rdata(fifo_rdata), .dreq(dreq), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .dbus_out(dbus_out), .dbus_oe(dbus_oe)
  );

  short_pkt_tracker #(.LENW(LENW)) u_trk (
    .clk(clk), .rst(rst), .dma_out(dma_out), .cont_mode(cont_mode), .wide(wide),
    .rx_pkt_valid(rx_pkt_valid), .rx_pkt_short(rx_pkt_short), .rx_pkt_len(rx_pkt_len),
    .word_read(fifo_rd), .irq_clr(irq_clr), .irq_rdy(irq_rdy), .short_len(short_len)
  );

  // R1
  cpu_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dreq) |-> $past(sel_valid && sel_cfg.dma));
endmodule

// File: tb/dma_single_xfer_bench.sv
module dma_single_xfer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LENW = 12;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_dma = 0, cfg_in = 0, wide = 1, cont_mode = 0;
  logic [2:0] cfg_ep = 0, dma_ep = 0;
  logic buf_has_data = 0, buf_has_space = 0, rx_pkt_valid = 0, rx_pkt_short = 0;
  logic [LENW-1:0] rx_pkt_len = 0;
  logic dack = 0, rd_strobe = 0, wr_strobe = 0, irq_clr = 0;
  logic [15:0] dbus_in = 0, fifo_rdata = 0;
  logic dreq, fifo_rd, fifo_wr, dbus_oe, irq_rdy;
  logic [15:0] fifo_wdata, dbus_out;
  logic [LENW-1:0] short_len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_single_xfer u_dma_single_xfer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_dma(cfg_dma), .cfg_in(cfg_in),
    .dma_ep(dma_ep), .wide(wide), .cont_mode(cont_mode), .buf_has_data(buf_has_data),
    .buf_has_space(buf_has_space), .rx_pkt_valid(rx_pkt_valid), .rx_pkt_short(rx_pkt_short),
    .rx_pkt_len(rx_pkt_len), .dack(dack), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .dbus_in(dbus_in), .fifo_rdata(fifo_rdata), .irq_clr(irq_clr), .dreq(dreq),
    .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe), .irq_rdy(irq_rdy), .short_len(short_len)
  );

  function automatic logic [15:0] exp_word(input logic [15:0] d, input logic w);
    return w ? d : {8'h00, d[7:0]};
  endfunction

  function automatic int reads_needed(input int len, input logic w);
    return w ? (len + 1) / 2 : len;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int ep, input logic dma, input logic dir_in);
    cfg_we = 1; cfg_ep = 3'(ep); cfg_dma = dma; cfg_in = dir_in;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic pkt(input logic shrt, input int len);
    rx_pkt_valid = 1; rx_pkt_short = shrt; rx_pkt_len = LENW'(len);
    cyc(1);
    rx_pkt_valid = 0; rx_pkt_short = 0;
  endtask

  // full read handshake on an OUT endpoint, entered at a negedge with the FSM idle
  task automatic dma_read(input logic [15:0] d, input string req);
    buf_has_data = 1;
    cyc(1);
    check(dreq == 1, "R2", dreq, 1);
    dack = 1;
    cyc(1);
    check(dreq == 0, "R3", dreq, 0);
    rd_strobe = 1; fifo_rdata = d;
    cyc(1);
    check(fifo_rd == 1 && dbus_oe == 1, "R4", {fifo_rd, dbus_oe}, 2'b11);
    check(dbus_out == exp_word(d, wide), req, dbus_out, exp_word(d, wide));
    rd_strobe = 0; dack = 0; buf_has_data = 0;
    cyc(1);
    check(fifo_rd == 0, "R5", fifo_rd, 0);
  endtask

  initial begin
    cyc(1);
    void'($urandom(32'd20240611));
    cyc(2);
    rst = 0;
    cyc(1);
    check(dreq == 0 && irq_rdy == 0 && dbus_oe == 0 && short_len == 0, "reset",
          {dreq, irq_rdy, dbus_oe}, 0);

    // R1: CPU mode and select 0 never request
    cfg(2, 0, 0); dma_ep = 2; buf_has_data = 1; buf_has_space = 1;
    cyc(4);
    check(dreq == 0, "R1", dreq, 0);
    dma_ep = 0; cfg(1, 1, 0);
    cyc(4);
    check(dreq == 0, "R1", dreq, 0);
    buf_has_data = 0; buf_has_space = 0;

    // R2: OUT endpoint ignores space, needs data
    dma_ep = 1; buf_has_space = 1;
    cyc(4);
    check(dreq == 0, "R2", dreq, 0);
    buf_has_space = 0;
    wide = 1; dma_read(16'hA55A, "R5");
    wide = 0; dma_read(16'hBEEF, "R5");

    // R4: strobe without ack, wrong-direction strobe, both ignored
    buf_has_data = 1;
    cyc(1);
    wr_strobe = 1; rd_strobe = 1;
    cyc(1);
    check(fifo_rd == 0 && dreq == 1, "R4", {fifo_rd, dreq}, 1);
    rd_strobe = 0; dack = 1;
    cyc(2);
    check(fifo_wr == 0 && fifo_rd == 0, "R4", {fifo_wr, fifo_rd}, 0);
    wr_strobe = 0; rd_strobe = 1; fifo_rdata = 16'h1234; wide = 1;
    cyc(1);
    check(fifo_rd == 1 && dbus_out == 16'h1234, "R4", dbus_out, 16'h1234);
    // R6: strobe held long, no new request while held
    dack = 0;
    cyc(4);
    check(dreq == 0 && fifo_rd == 0, "R6", {dreq, fifo_rd}, 0);
    rd_strobe = 0;
    cyc(1);
    check(dreq == 0, "R6", dreq, 0);
    cyc(1);
    check(dreq == 1, "R6", dreq, 1);
    dack = 1; buf_has_data = 0;
    cyc(1);
    rd_strobe = 1;
    cyc(1);
    rd_strobe = 0; dack = 0;
    cyc(2);

    // IN endpoint: write handshake (R2, R4, R5)
    cfg(3, 1, 1); dma_ep = 3; buf_has_data = 1;
    cyc(3);
    check(dreq == 0, "R2", dreq, 0);
    buf_has_data = 0; buf_has_space = 1;
    cyc(1);
    check(dreq == 1, "R2", dreq, 1);
    dack = 1;
    cyc(1);
    wide = 0; wr_strobe = 1; dbus_in = 16'hC3D4;
    cyc(1);
    check(fifo_wr == 1 && fifo_wdata == 16'h00D4, "R5", fifo_wdata, 16'h00D4);
    wr_strobe = 0; dack = 0; buf_has_space = 0;
    cyc(2);
    // R8: IN short packet ignored
    pkt(1, 0);
    cyc(2);
    check(irq_rdy == 0 && short_len == 0, "R8", {irq_rdy, short_len}, 0);

    // R7, R9: OUT short packet of 5 bytes, 16-bit reads
    dma_ep = 1; cont_mode = 0; wide = 1;
    pkt(1, 5);
    check(short_len == 5, "R9", short_len, 5);
    for (int i = 0; i < 3; i++) begin
      check(irq_rdy == 0, "R7", irq_rdy, 0);
      dma_read(16'(i), "R5");
    end
    check(irq_rdy == 1, "R7", irq_rdy, 1);
    // R11: sticky then cleared
    cyc(5);
    check(irq_rdy == 1, "R11", irq_rdy, 1);
    irq_clr = 1; cyc(1); irq_clr = 0;
    check(irq_rdy == 0, "R11", irq_rdy, 0);
    // R7: zero-length short sets at once
    pkt(1, 0);
    check(irq_rdy == 1, "R7", irq_rdy, 1);
    irq_clr = 1; cyc(1); irq_clr = 0;

    // R10: continuous mode accumulation
    cont_mode = 1;
    pkt(0, 64); pkt(0, 64); pkt(0, 32); pkt(1, 7);
    check(short_len == 160, "R10", short_len, 160);
    wide = 0;
    for (int i = 0; i < 7; i++) dma_read(16'h0100 + 16'(i), "R5");
    check(irq_rdy == 1, "R7", irq_rdy, 1);
    irq_clr = 1; cyc(1); irq_clr = 0;
    cont_mode = 0;

    // random short packets with random widths
    for (int t = 0; t < 25; t++) begin
      int len, n;
      len  = 1 + int'($urandom_range(0, 12));
      wide = logic'($urandom_range(0, 1));
      n    = reads_needed(len, wide);
      pkt(1, len);
      check(short_len == LENW'(len), "R9", short_len, len);
      for (int k = 0; k < n; k++) begin
        check(irq_rdy == 0, "R7", irq_rdy, 0);
        dma_read(16'($urandom()), "R5");
      end
      check(irq_rdy == 1, "R7", irq_rdy, 1);
      irq_clr = 1; cyc(1); irq_clr = 0;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule